// File: doc/BRIEF.md
# Four-Slot ADC Conversion Sequencer

This block runs an external 8-bit, 8-channel converter datapath through groups of four conversions. Software uses a small register bus with an address, write data, a write strobe and a combinational read port. Behind that bus sit a control/status register, four result registers and an option register that holds the converter power enable. The block never samples or converts anything itself. It drives a 3-bit channel number and a sample-hold strobe, and it captures an 8-bit code when the datapath pulses done.

Writing the control/status register starts a fixed cycle of four conversions. Each conversion takes 32 clocks, and the strobe is high for the first 12 of them. The four codes fill the result registers in order. In single-channel mode all four come from one input. In group mode they come from four adjacent inputs, either the low group or the high group. After the fourth code, a completion flag goes high. In one-shot mode the block then goes idle. In continuous mode it keeps cycling and rewrites each result register in place.

Top module: `adc_seq`

## Requirements
- R1: After reset, every register reads 0: control/status at address 0, results at addresses 1 to 4, and option at address 5. The strobe is low.
- R2: A write to address 0 stores bits 5..0, where bit 5 selects continuous mode, bit 4 selects group mode, and bits 3..0 are the selection field. Written bits 7 and 6 are ignored. A read of address 0 returns the flag in bit 7, 0 in bit 6, and the stored bits 5..0 as written.
- R3: In single-channel mode (bit 4 = 0), all four conversions drive the channel number with selection bits 2..0.
- R4: In group mode (bit 4 = 1), the conversions drive channel {sel[2], k}, where k runs 0, 1, 2, 3. Selection bits 1..0 have no effect on the channel.
- R5: The code taken by conversion k (k = 0..3) is stored in the result register at address k+1.
- R6: In one-shot mode (bit 5 = 0), the flag reads 0 while a cycle is running and becomes 1 after the fourth code is captured. The strobe then stays low until the next start.
- R7: A conversion lasts 32 clocks, and the strobe is high during its first 12. A done pulse is only taken in the 32nd clock. Until done arrives, the block waits in that clock.
- R8: In continuous mode (bit 5 = 1), cycles repeat with no gap. Once the flag is set it stays set, and each result register is overwritten by later codes for its slot.
- R9: Bit 7 of the option register at address 5 powers the converter. A write to address 0 while this bit is 0 stores the configuration but starts nothing. Clearing the bit stops a running cycle.
- R10: A write to address 0 during a running cycle aborts it, clears the flag and restarts at slot 0 with a fresh 32-clock conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per clock |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| conv_chan | output | 3 | Channel number for the converter |
| conv_sample | output | 1 | Sample-hold strobe |
| conv_code | input | 8 | Code returned by the converter |
| conv_done | input | 1 | Converter done pulse |

## Verification
The sequencer is run with several control patterns, and each one separates a different failure:
- A single-channel selection with junk in bits 7 and 6 shows whether the read-only bits are filtered and whether the channel stays fixed.
- A high-group selection with both low selection bits set exposes any use of those bits in the channel number.
- A continuous run over a reserved-bit channel-0 selection shows whether the flag is sticky and whether results are refreshed in place.
- A mid-cycle rewrite and a mid-cycle power-down show whether the timer and slot restart or stop.

The stand-in converter returns codes that mix the channel with a running count, so a result written to the wrong slot, from a stale conversion, or from the wrong channel differs from the model.

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int DW         = 8,
  parameter int AW         = 3,
  parameter int CONV_CYC   = 32,
  parameter int SAMPLE_CYC = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_we,
  output logic [DW-1:0] bus_rdata,
  output logic [2:0]    conv_chan,
  output logic          conv_sample,
  input  logic [DW-1:0] conv_code,
  input  logic          conv_done
);
  localparam int NSLOT = 4;
  localparam int CW    = $clog2(CONV_CYC);
  localparam logic [AW-1:0] A_CTL = AW'(0);
  localparam logic [AW-1:0] A_OPT = AW'(5);
  localparam logic [CW-1:0] LAST  = CW'(CONV_CYC - 1);

  logic [5:0]    cfg;
  logic          ccf, pwr, busy;
  logic [CW-1:0] ctr;
  logic [1:0]    slot;
  logic [DW-1:0] res [NSLOT];

  wire wr_ctl = bus_we && (bus_addr == A_CTL);
  wire wr_opt = bus_we && (bus_addr == A_OPT);
  wire take   = busy && pwr && !wr_ctl && (ctr == LAST) && conv_done;
  wire scan   = cfg[5];
  wire mult   = cfg[4];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      pwr <= 1'b0;
    else if (wr_opt) pwr <= bus_wdata[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg  <= '0;
      ccf  <= 1'b0;
      busy <= 1'b0;
      ctr  <= '0;
      slot <= '0;
    end else if (wr_ctl) begin
      cfg  <= bus_wdata[5:0];
      ccf  <= 1'b0;
      busy <= pwr;
      ctr  <= '0;
      slot <= '0;
    end else if (!pwr) begin
      busy <= 1'b0;
    end else if (busy) begin
      if (take) begin
        ctr  <= '0;
        slot <= slot + 2'd1;
        if (slot == 2'd3) begin
          ccf <= 1'b1;
          if (!scan) busy <= 1'b0;
        end
      end else if (ctr != LAST) begin
        ctr <= ctr + CW'(1);
      end
    end
  end

  for (genvar k = 0; k < NSLOT; k++) begin : g_res
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                         res[k] <= '0;
      else if (take && slot == 2'(k))     res[k] <= conv_code;
  end

  assign conv_chan   = mult ? {cfg[2], slot} : cfg[2:0];
  assign conv_sample = busy && (ctr < CW'(SAMPLE_CYC));

  always_comb begin
    case (bus_addr)
      A_CTL:   bus_rdata = DW'({ccf, 1'b0, cfg});
      AW'(1):  bus_rdata = res[0];
      AW'(2):  bus_rdata = res[1];
      AW'(3):  bus_rdata = res[2];
      AW'(4):  bus_rdata = res[3];
      A_OPT:   bus_rdata = {pwr, {(DW-1){1'b0}}};
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int AW = 3,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic          conv_done,
  input logic          conv_sample,
  input logic          busy,
  input logic          ccf,
  input logic          pwr,
  input logic [CW-1:0] ctr,
  input logic [1:0]    slot,
  input logic [5:0]    cfg
);
  wire wr   = bus_we && (bus_addr == '0);
  wire last = (ctr == {CW{1'b1}});
  wire tk   = busy && pwr && !wr && last && conv_done;

  a_r7_strobe_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    conv_sample |-> busy);

  a_r7_wait_for_done: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pwr && !wr && last && !conv_done) |=> (busy && last));

  a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (ctr == '0 && slot == 2'd0 && !ccf));

  a_r9_unpowered_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr |=> !busy);

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ccf && !wr) |=> ccf);

  a_r6_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (tk && slot == 2'd3 && !cfg[5]) |=> (!busy && ccf));

  a_r5_slot_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (tk && slot != 2'd3) |=> (slot == $past(slot) + 2'd1 && !ccf == !$past(ccf)));
endmodule

bind adc_seq adc_seq_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .conv_done(conv_done), .conv_sample(conv_sample), .busy(busy), .ccf(ccf),
  .pwr(pwr), .ctr(ctr), .slot(slot), .cfg(cfg)
);

// File: tb/adc_seq_test.sv
module adc_seq_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_rdata;
  logic [2:0] conv_chan;
  logic       conv_sample;
  logic [7:0] conv_code = '0;
  logic       conv_done = 1'b0;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  adc_seq uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .conv_chan(conv_chan),
    .conv_sample(conv_sample), .conv_code(conv_code), .conv_done(conv_done)
  );

  // behavioural reference
  int m_ctr, m_slot, m_busy, m_ccf, m_pwr, m_cfg;
  int m_res[4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctr = 0; m_slot = 0; m_busy = 0; m_ccf = 0; m_pwr = 0; m_cfg = 0;
      foreach (m_res[i]) m_res[i] = 0;
    end else begin
      int old_pwr;
      old_pwr = m_pwr;
      if (bus_we && bus_addr == 5) m_pwr = bus_wdata[7];
      if (bus_we && bus_addr == 0) begin
        m_cfg = bus_wdata & 8'h3f; m_ccf = 0; m_slot = 0; m_ctr = 0; m_busy = old_pwr;
      end else if (!old_pwr) begin
        m_busy = 0;
      end else if (m_busy != 0) begin
        if (m_ctr == 31) begin
          if (conv_done) begin
            m_res[m_slot] = conv_code;
            if (m_slot == 3) begin
              m_ccf = 1;
              if ((m_cfg & 32) == 0) m_busy = 0;
            end
            m_slot = (m_slot + 1) % 4;
            m_ctr = 0;
          end
        end else m_ctr++;
      end
    end
  end

  function automatic int exp_chan();
    if ((m_cfg & 16) != 0) return ((m_cfg & 4) != 0 ? 4 : 0) + m_slot;
    return m_cfg & 7;
  endfunction

  function automatic int exp_rd(int a);
    case (a)
      0: return m_ccf * 128 + m_cfg;
      1, 2, 3, 4: return m_res[a-1];
      5: return m_pwr * 128;
      default: return 0;
    endcase
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle compare plus converter stand-in
  int lowrun = 100, ndone = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      check("R7", "strobe", conv_sample, (m_busy != 0 && m_ctr < 12) ? 1 : 0);
      if (m_busy != 0) check((m_cfg & 16) != 0 ? "R4" : "R3", "chan", conv_chan, exp_chan());
      if (conv_sample) lowrun = 0; else if (lowrun < 1000) lowrun++;
      conv_done = (lowrun == 20);
      conv_code = {conv_chan, ndone[4:0]};
      if (conv_done) ndone++;
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); #1;
    bus_addr = 3'(a); bus_wdata = 8'(d); bus_we = 1'b1;
    @(negedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(string req, int a);
    @(negedge clk); #1;
    bus_addr = 3'(a);
    #1 check(req, $sformatf("rd%0d", a), bus_rdata, exp_rd(a));
  endtask

  task automatic rd_lit(string req, int a, int exp);
    @(negedge clk); #1;
    bus_addr = 3'(a);
    #1 check(req, $sformatf("rd%0d", a), bus_rdata, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 6; a++) rd_lit("R1", a, 0);
    check("R1", "strobe", conv_sample, 0);

    // R9 start without power
    wr(0, 8'h03);
    idle(40);
    rd_lit("R9", 0, 8'h03);
    check("R9", "strobe", conv_sample, 0);

    // R2 R3 R5 R6 single channel one-shot, junk in bits 7..6
    wr(5, 8'h80);
    rd_lit("R9", 5, 8'h80);
    wr(0, 8'hC5);
    idle(60);
    rd_lit("R6", 0, 8'h05);
    idle(90);
    rd_lit("R2", 0, 8'h85);
    for (int a = 1; a < 5; a++) rd("R5", a);
    rd_lit("R5", 1, {3'd5, 5'd0});
    rd_lit("R5", 4, {3'd5, 5'd3});
    idle(40);
    check("R6", "strobe", conv_sample, 0);

    // R4 high group with low select bits set
    wr(0, 8'h17);
    idle(140);
    rd_lit("R4", 0, 8'h97);
    for (int a = 1; a < 5; a++) rd("R4", a);
    rd_lit("R4", 3, {3'd6, 5'd6});

    // R8 continuous, reserved bit readback, channel 0
    wr(0, 8'h28);
    idle(140);
    rd_lit("R8", 0, 8'hA8);
    rd("R8", 1);
    idle(70);
    rd_lit("R8", 0, 8'hA8);
    rd_lit("R8", 1, {3'd0, 5'd12});
    rd("R8", 2);
    idle(100);
    for (int a = 1; a < 5; a++) rd("R8", a);

    // R10 abort mid-cycle
    idle(17);
    wr(0, 8'h10);
    rd_lit("R10", 0, 8'h10);
    idle(50);
    wr(0, 8'h10);
    idle(140);
    rd_lit("R10", 0, 8'h90);
    for (int a = 1; a < 5; a++) rd("R10", a);

    // R9 power down mid-cycle
    wr(0, 8'h30);
    idle(45);
    wr(5, 8'h00);
    idle(60);
    check("R9", "strobe", conv_sample, 0);
    rd_lit("R9", 0, 8'h30);
    for (int a = 1; a < 6; a++) rd("R9", a);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule